// File: doc/BRIEF.md
# BCD Calendar and Time-of-Day Counter

This core keeps the time of day and the calendar date as BCD digits. Every digit is a separate output, so a display stage can use the digits without any conversion. The core counts seconds, minutes and hours on a 24-hour day, then days, months and a four-digit year. It advances once per cycle in which the one-per-second `tick` input is high.

The length of each month comes from the month value and a leap flag. The leap flag is worked out directly from the BCD year digits. All carries pass combinationally, so one tick can roll the whole state over, for example from the last second of a year into the first second of the next year.

A load port writes two BCD digits into one selected field at a time. This lets software or a button handler preset the date and time. Counting continues from the loaded value.

A `show_date` output alternates every few seconds. When it is low, the display shows the time view, laid out as hh-mm-ss. When it is high, the display shows the date view, laid out as YYYY-MM-DD.

Top module: `bcd_calendar_clock`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes 2000-01-01 00:00:00 and `show_date` becomes 0 (time view). Reset overrides both tick and load.
- R2: When `tick` is low and `ld_en` is low, no digit and no view output changes.
- R3: Seconds and minutes count 00 to 59 with BCD units carry. When seconds are 59 and a tick arrives, seconds become 00 and minutes advance. When minutes are 59 and they advance, minutes become 00 and hours advance.
- R4: Hours count 00 to 23. A tick at 23:59:59 gives 00:00:00 and advances the day.
- R5: Month lengths are as follows. Months 01, 03, 05, 07, 08, 10 and 12 have 31 days. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when `leap` is 1 and 28 days otherwise. When the day is at or above the month length and it advances, the day becomes 01 and the month advances.
- R6: When the month is 12 and it advances, the month becomes 01 and the year advances. The year counts 0000 to 9999 and then wraps to 0000. The whole ripple finishes within one tick.
- R7: `leap` is 1 when the selected digit pair is divisible by 4. The selected pair is the upper year pair if both lower year digits are 0, and the lower pair otherwise. A pair is divisible by 4 when (2 if the tens digit is odd, else 0) plus the units digit, taken modulo 4, is 0.
- R8: With `ld_en` high, `ld_sel` picks a field. The codes are 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 lower year pair and 6 upper year pair. Code 7 writes nothing. The field becomes {`ld_hi`,`ld_lo`}, with `ld_hi` as the tens digit and `ld_lo` as the units digit, at that edge whether or not `tick` is high.
- R9: In a cycle where a field is loaded, that field ignores any carry into it. It also passes no carry on to the next field. All other fields keep counting normally.
- R10: `show_date` toggles on every 4th tick since reset. Loads do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse once per second; all counting is gated by it |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Field select for a load |
| ld_hi | input | 4 | Tens BCD digit to load |
| ld_lo | input | 4 | Units BCD digit to load |
| sec_t | output | 4 | Seconds tens digit |
| sec_u | output | 4 | Seconds units digit |
| min_t | output | 4 | Minutes tens digit |
| min_u | output | 4 | Minutes units digit |
| hr_t | output | 4 | Hours tens digit |
| hr_u | output | 4 | Hours units digit |
| day_t | output | 4 | Day tens digit |
| day_u | output | 4 | Day units digit |
| mon_t | output | 4 | Month tens digit |
| mon_u | output | 4 | Month units digit |
| yr_3 | output | 4 | Year thousands digit |
| yr_2 | output | 4 | Year hundreds digit |
| yr_1 | output | 4 | Year tens digit |
| yr_0 | output | 4 | Year units digit |
| leap | output | 1 | Current year is a leap year |
| show_date | output | 1 | 1 selects the date view, 0 selects the time view |

## Verification
The month-end and year-end rollovers would take years of ticks to reach by counting from reset. Each such case is reached instead by loading all seven fields to the second before the boundary and then giving one tick.

The cases cover:
- each month length, including February in common years, in leap years and in century years;
- the complete rollover from 9999-12-31 23:59:59 to 0000-01-01 00:00:00;
- a load and a tick in the same cycle, which exercises the carry-suppression rule.

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
  parameter int          VIEW_TICKS = 4,
  parameter logic [15:0] RST_YEAR   = 16'h2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       ld_en,
  input  logic [2:0] ld_sel,
  input  logic [3:0] ld_hi,
  input  logic [3:0] ld_lo,
  output logic [3:0] sec_t,
  output logic [3:0] sec_u,
  output logic [3:0] min_t,
  output logic [3:0] min_u,
  output logic [3:0] hr_t,
  output logic [3:0] hr_u,
  output logic [3:0] day_t,
  output logic [3:0] day_u,
  output logic [3:0] mon_t,
  output logic [3:0] mon_u,
  output logic [3:0] yr_3,
  output logic [3:0] yr_2,
  output logic [3:0] yr_1,
  output logic [3:0] yr_0,
  output logic       leap,
  output logic       show_date
);
  localparam int VW = (VIEW_TICKS > 1) ? $clog2(VIEW_TICKS) : 1;

  logic [7:0] sec, mins, hrs, day, mon, ylo, yhi;
  logic [7:0] last_day, pair, ld_val;
  logic [VW-1:0] vcnt;

  function automatic logic [7:0] step(input logic [7:0] v, input logic wrap, input logic [7:0] first);
    if (wrap) return first;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign ld_val = {ld_hi, ld_lo};

  wire ld_s  = ld_en && ld_sel == 3'd0;
  wire ld_m  = ld_en && ld_sel == 3'd1;
  wire ld_h  = ld_en && ld_sel == 3'd2;
  wire ld_d  = ld_en && ld_sel == 3'd3;
  wire ld_mo = ld_en && ld_sel == 3'd4;
  wire ld_yl = ld_en && ld_sel == 3'd5;
  wire ld_yh = ld_en && ld_sel == 3'd6;

  wire s_end  = sec  == 8'h59;
  wire m_end  = mins == 8'h59;
  wire h_end  = hrs  == 8'h23;
  wire d_end  = day  >= last_day;
  wire mo_end = mon  >= 8'h12;
  wire yl_end = ylo  == 8'h99;
  wire yh_end = yhi  == 8'h99;

  wire inc_m  = tick   && s_end  && !ld_s;
  wire inc_h  = inc_m  && m_end  && !ld_m;
  wire inc_d  = inc_h  && h_end  && !ld_h;
  wire inc_mo = inc_d  && d_end  && !ld_d;
  wire inc_yl = inc_mo && mo_end && !ld_mo;
  wire inc_yh = inc_yl && yl_end && !ld_yl;

  assign pair = (ylo == 8'h00) ? yhi : ylo;
  assign leap = ((pair[4] ? 2'd2 : 2'd0) + pair[1:0]) == 2'd0;

  always_comb begin
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec  <= 8'h00;
      mins <= 8'h00;
      hrs  <= 8'h00;
      day  <= 8'h01;
      mon  <= 8'h01;
      ylo  <= RST_YEAR[7:0];
      yhi  <= RST_YEAR[15:8];
    end else begin
      if (ld_s) sec <= ld_val;
      else if (tick) sec <= step(sec, s_end, 8'h00);
      if (ld_m) mins <= ld_val;
      else if (inc_m) mins <= step(mins, m_end, 8'h00);
      if (ld_h) hrs <= ld_val;
      else if (inc_h) hrs <= step(hrs, h_end, 8'h00);
      if (ld_d) day <= ld_val;
      else if (inc_d) day <= step(day, d_end, 8'h01);
      if (ld_mo) mon <= ld_val;
      else if (inc_mo) mon <= step(mon, mo_end, 8'h01);
      if (ld_yl) ylo <= ld_val;
      else if (inc_yl) ylo <= step(ylo, yl_end, 8'h00);
      if (ld_yh) yhi <= ld_val;
      else if (inc_yh) yhi <= step(yhi, yh_end, 8'h00);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt      <= '0;
      show_date <= 1'b0;
    end else if (tick) begin
      if (vcnt == VW'(VIEW_TICKS - 1)) begin
        vcnt      <= '0;
        show_date <= !show_date;
      end else begin
        vcnt <= vcnt + 1'b1;
      end
    end
  end

  assign {sec_t, sec_u} = sec;
  assign {min_t, min_u} = mins;
  assign {hr_t, hr_u}   = hrs;
  assign {day_t, day_u} = day;
  assign {mon_t, mon_u} = mon;
  assign {yr_1, yr_0}   = ylo;
  assign {yr_3, yr_2}   = yhi;

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_en) |=> $stable({sec, mins, hrs, day, mon, ylo, yhi, show_date}));

  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && sec == 8'h59) |=> (sec == 8'h00));

  a_r4_midnight: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && {hrs, mins, sec} == 24'h235959) |=> ({hrs, mins, sec} == 24'h0 && day != $past(day)));

  a_r6_year_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && {yhi, ylo, mon, day, hrs, mins, sec} == 56'h9999_1231_235959)
    |=> ({yhi, ylo, mon, day} == 32'h0000_0101));

  a_r8_load_sec: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_sel == 3'd0) |=> (sec == {$past(ld_hi), $past(ld_lo)}));

  a_r10_view_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(show_date));
endmodule

// File: tb/sim_bcd_calendar_clock.sv
module sim_bcd_calendar_clock;
  logic clk = 0, rst = 1, tick = 0, ld_en = 0;
  logic [2:0] ld_sel = 0;
  logic [3:0] ld_hi = 0, ld_lo = 0;
  logic [3:0] sec_t, sec_u, min_t, min_u, hr_t, hr_u, day_t, day_u, mon_t, mon_u;
  logic [3:0] yr_3, yr_2, yr_1, yr_0;
  logic leap, show_date;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  bcd_calendar_clock u0 (.clk, .rst, .tick, .ld_en, .ld_sel, .ld_hi, .ld_lo,
    .sec_t, .sec_u, .min_t, .min_u, .hr_t, .hr_u, .day_t, .day_u, .mon_t, .mon_u,
    .yr_3, .yr_2, .yr_1, .yr_0, .leap, .show_date);

  function automatic logic [55:0] now();
    return {yr_3, yr_2, yr_1, yr_0, mon_t, mon_u, day_t, day_u, hr_t, hr_u, min_t, min_u, sec_t, sec_u};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; tick = 0; ld_en = 0;
    @(negedge clk); rst = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic load(logic [2:0] sel, logic [7:0] v, logic t);
    @(negedge clk); ld_en = 1; ld_sel = sel; {ld_hi, ld_lo} = v; tick = t;
    @(negedge clk); ld_en = 0; tick = 0;
  endtask

  task automatic set_all(logic [55:0] d);
    load(3'd6, d[55:48], 0); load(3'd5, d[47:40], 0); load(3'd4, d[39:32], 0);
    load(3'd3, d[31:24], 0); load(3'd2, d[23:16], 0); load(3'd1, d[15:8], 0);
    load(3'd0, d[7:0], 0);
  endtask

  task automatic roll(string req, logic [55:0] start, logic [55:0] exp);
    set_all(start);
    ticks(1);
    chk(req, 64'(now()), 64'(exp));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset date/time", 64'(now()), 64'h2000_0101_000000);
    chk("R1 reset view", 64'(show_date), 64'd0);
    chk("R7 leap 2000", 64'(leap), 64'd1);
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    chk("R2 hold without tick", 64'(now()), 64'h2000_0101_000000);
    load(3'd7, 8'h45, 0);
    chk("R8 sel 7 writes nothing", 64'(now()), 64'h2000_0101_000000);
  endtask

  task automatic t_view();
    do_reset();
    ticks(3);
    chk("R10 view after 3 ticks", 64'(show_date), 64'd0);
    ticks(1);
    chk("R10 view after 4 ticks", 64'(show_date), 64'd1);
    load(3'd0, 8'h30, 0);
    repeat (3) @(negedge clk);
    chk("R10 view unaffected by load/idle", 64'(show_date), 64'd1);
    ticks(4);
    chk("R10 view after 8 ticks", 64'(show_date), 64'd0);
  endtask

  task automatic t_sec_min();
    do_reset();
    ticks(9);
    chk("R3 units carry", 64'(now()), 64'h2000_0101_000009);
    ticks(50);
    chk("R3 seconds 59", 64'(now()), 64'h2000_0101_000059);
    ticks(1);
    chk("R3 seconds wrap into minutes", 64'(now()), 64'h2000_0101_000100);
    roll("R3 minute wrap into hour", 56'h2000_0101_005959, 56'h2000_0101_010000);
    roll("R3 hour units carry", 56'h2000_0101_095959, 56'h2000_0101_100000);
  endtask

  task automatic t_midnight();
    roll("R4 midnight advances day", 56'h2000_0101_235959, 56'h2000_0102_000000);
    roll("R4 hour 22 to 23", 56'h2000_0101_225959, 56'h2000_0101_230000);
  endtask

  task automatic t_months();
    roll("R5 Jan 31", 56'h2023_0131_235959, 56'h2023_0201_000000);
    roll("R5 Apr 30", 56'h2023_0430_235959, 56'h2023_0501_000000);
    roll("R5 Apr 29 no wrap", 56'h2023_0429_235959, 56'h2023_0430_000000);
    roll("R5 Sep day units carry", 56'h2023_0909_235959, 56'h2023_0910_000000);
    roll("R5 Nov 30", 56'h2023_1130_235959, 56'h2023_1201_000000);
    roll("R5 Feb 28 common", 56'h2023_0228_235959, 56'h2023_0301_000000);
    roll("R5 Feb 28 leap", 56'h2024_0228_235959, 56'h2024_0229_000000);
    roll("R5 Feb 29 leap", 56'h2024_0229_235959, 56'h2024_0301_000000);
    roll("R5 Feb 1900", 56'h1900_0228_235959, 56'h1900_0301_000000);
    roll("R5 Feb 2000", 56'h2000_0228_235959, 56'h2000_0229_000000);
    roll("R5 Aug 31", 56'h2023_0831_235959, 56'h2023_0901_000000);
  endtask

  task automatic t_years();
    roll("R6 Dec 31", 56'h2023_1231_235959, 56'h2024_0101_000000);
    roll("R6 century", 56'h2099_1231_235959, 56'h2100_0101_000000);
    chk("R7 leap 2100", 64'(leap), 64'd0);
    roll("R6 full wrap", 56'h9999_1231_235959, 56'h0000_0101_000000);
    chk("R7 leap 0000", 64'(leap), 64'd1);
  endtask

  task automatic t_leap();
    set_all(56'h2024_0101_000000); chk("R7 leap 2024", 64'(leap), 64'd1);
    set_all(56'h2023_0101_000000); chk("R7 leap 2023", 64'(leap), 64'd0);
    set_all(56'h2400_0101_000000); chk("R7 leap 2400", 64'(leap), 64'd1);
    set_all(56'h1996_0101_000000); chk("R7 leap 1996", 64'(leap), 64'd1);
    set_all(56'h1900_0101_000000); chk("R7 leap 1900", 64'(leap), 64'd0);
  endtask

  task automatic t_priority();
    set_all(56'h2000_0101_000059);
    load(3'd1, 8'h30, 1);
    chk("R9 loaded minute ignores carry", 64'(now()), 64'h2000_0101_003000);
    set_all(56'h2000_0101_000559);
    load(3'd0, 8'h10, 1);
    chk("R9 loaded second gives no carry", 64'(now()), 64'h2000_0101_000510);
    set_all(56'h2000_0101_120000);
    load(3'd4, 8'h07, 1);
    chk("R8 load with tick, others count", 64'(now()), 64'h2000_0701_120001);
  endtask

  task automatic t_rst_prio();
    set_all(56'h2000_0315_101010);
    @(negedge clk); rst = 1; tick = 1; ld_en = 1; ld_sel = 3'd0; {ld_hi, ld_lo} = 8'h42;
    @(negedge clk); rst = 0; tick = 0; ld_en = 0;
    chk("R1 reset overrides tick/load", 64'(now()), 64'h2000_0101_000000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_view();
    t_sec_min();
    t_midnight();
    t_months();
    t_years();
    t_leap();
    t_priority();
    t_rst_prio();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule